// File: doc/BRIEF.md
# ADC Tracking and Burst-Power Sequencer

This block is the digital control sequencer placed in front of a successive-approximation ADC. A single-cycle convert request makes it run a short sequence. It may first wake the analog core from a low-power state and wait a programmable startup time. It may then hold the track/hold switch in track for a programmed settling window. Finally it pulses a go strobe to the SAR engine and waits for that engine to report done. Between conversions the track/hold output either tracks the input or stays on hold, depending on the selected tracking style.

An 8-bit configuration word sets the behaviour. The upper nibble is a startup count in units of `STEP_CYCLES` system clocks. Bits [3:2] choose the tracking style. Bits [1:0] set the post-convert-request tracking length. The SAR part of that window advances only on cycles where the SAR clock-enable tick is high, and two system-clock cycles always follow it. A burst input together with the ADC enable decides whether the core is powered all the time, only while a conversion runs, or only when enabled.

Top module: `adc_track_seq`

## Requirements
- R1: After reset the configuration reads 0xFF. A write with `cfg_we_i` high is visible on `cfg_o` from the next cycle. The fields are: bits [7:4] startup count, bits [3:2] tracking style, bits [1:0] post-track length.
- R2: With style 2'b10 (track before), `track_o` is high while idle and powered. `conv_go_o` is high in the cycle after the clock edge that samples `start_i`. `track_o` is low from the go cycle until the conversion completes.
- R3: With style 2'b01 (track after), `track_o` is low while idle. After a request it is high for (2 << post-track length) SAR ticks plus 2 clocks, and then `conv_go_o` pulses. The go pulse comes 3 + (2 << length) edges after the request when the tick is constantly high.
- R4: With style 2'b11 (track both), `track_o` is high while idle and also throughout the post-request window. The go timing is the same as in R3.
- R5: During the SAR part of the post-track window, cycles with `sar_tick_i` low do not advance the sequence.
- R6: With `burst_i` low, `pwr_on_o` equals `en_i`.
- R7: With `burst_i` and `en_i` both high, `pwr_on_o` stays high, including through a whole conversion.
- R8: With `burst_i` high and `en_i` low, `pwr_on_o` is low while idle. It goes high in the cycle after a request and stays high until completion. Tracking is held off for (count + 1) × `STEP_CYCLES` cycles, which adds that many edges to the go latency.
- R9: `conv_go_o` is high for exactly one cycle per conversion. `busy_o` is high from the cycle after a request until the cycle after `sar_done_i` is seen during conversion.
- R10: A `start_i` seen while `busy_o` is high has no effect. This includes a request in the same cycle as `sar_done_i`.
- R11: Style 2'b00 behaves exactly like 2'b01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_o | output | 8 | Current configuration word |
| en_i | input | 1 | ADC enable |
| burst_i | input | 1 | Burst low-power enable |
| sar_tick_i | input | 1 | SAR clock-enable tick |
| start_i | input | 1 | Convert request pulse |
| sar_done_i | input | 1 | SAR engine finished |
| pwr_on_o | output | 1 | Analog core power enable |
| track_o | output | 1 | Track (1) / hold (0) control |
| conv_go_o | output | 1 | One-cycle start strobe to the SAR engine |
| busy_o | output | 1 | Sequence in progress |

## Verification
A new convert request and the SAR engine's done can arrive in the same cycle. The question is then whether the request starts a second conversion or is dropped. The bench drives `start_i` and `sar_done_i` high on the same clock while the block waits in conversion. It then requires `busy_o` to fall and stay low, with no further `conv_go_o`, over the following cycles. This shows that the request was judged against the busy state that existed before completion.

// File: rtl/adc_track_pkg.sv
package adc_track_pkg;

  typedef enum logic [1:0] {
    MODE_RSVD = 2'b00,
    MODE_POST = 2'b01,
    MODE_PRE  = 2'b10,
    MODE_DUAL = 2'b11
  } trk_mode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_PWRUP,
    S_POST_SAR,
    S_POST_SYS,
    S_GO,
    S_CONV
  } seq_state_e;

  typedef struct packed {
    logic [3:0] pwr_cnt;
    trk_mode_e  mode;
    logic [1:0] post_len;
  } cfg_t;

  localparam int unsigned SYS_TAIL = 2;

endpackage

// File: rtl/adc_track_cfg.sv
module adc_track_cfg
  import adc_track_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  output cfg_t       cfg_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_o <= cfg_t'(8'hFF);
    else if (we_i) cfg_o <= cfg_t'(wdata_i);
  end

endmodule

// File: rtl/adc_track_timer.sv
module adc_track_timer #(
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  input  logic          dec_i,
  output logic          zero_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (load_i) cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/adc_track_fsm.sv
module adc_track_fsm
  import adc_track_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 40,
  parameter int unsigned CW          = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  cfg_t          cfg_i,
  input  logic          en_i,
  input  logic          burst_i,
  input  logic          sar_tick_i,
  input  logic          start_i,
  input  logic          sar_done_i,
  input  logic          zero_i,
  output logic          load_o,
  output logic [CW-1:0] load_val_o,
  output logic          dec_o,
  output logic          pwr_on_o,
  output logic          track_o,
  output logic          conv_go_o,
  output logic          busy_o
);

  seq_state_e state_q, state_d;

  logic          low_pw;
  logic          post_needed;
  logic          idle_tracks;
  logic [CW-1:0] pwrup_val;
  logic [CW-1:0] sar_val;

  assign low_pw      = burst_i & ~en_i;
  assign post_needed = (cfg_i.mode != MODE_PRE);
  assign idle_tracks = (cfg_i.mode == MODE_PRE) || (cfg_i.mode == MODE_DUAL);
  assign pwrup_val   = CW'((int'(cfg_i.pwr_cnt) + 1) * int'(STEP_CYCLES) - 1);
  assign sar_val     = CW'((2 << cfg_i.post_len) - 1);

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    dec_o      = 1'b0;
    unique case (state_q)
      S_IDLE: begin
        if (start_i) begin
          if (low_pw) begin
            state_d    = S_PWRUP;
            load_o     = 1'b1;
            load_val_o = pwrup_val;
          end else if (post_needed) begin
            state_d    = S_POST_SAR;
            load_o     = 1'b1;
            load_val_o = sar_val;
          end else begin
            state_d = S_GO;
          end
        end
      end
      S_PWRUP: begin
        if (zero_i) begin
          if (post_needed) begin
            state_d    = S_POST_SAR;
            load_o     = 1'b1;
            load_val_o = sar_val;
          end else begin
            state_d = S_GO;
          end
        end else begin
          dec_o = 1'b1;
        end
      end
      S_POST_SAR: begin
        if (sar_tick_i) begin
          if (zero_i) begin
            state_d    = S_POST_SYS;
            load_o     = 1'b1;
            load_val_o = CW'(SYS_TAIL - 1);
          end else begin
            dec_o = 1'b1;
          end
        end
      end
      S_POST_SYS: begin
        if (zero_i) state_d = S_GO;
        else        dec_o   = 1'b1;
      end
      S_GO:   state_d = S_CONV;
      S_CONV: if (sar_done_i) state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= S_IDLE;
    else         state_q <= state_d;
  end

  assign busy_o    = (state_q != S_IDLE);
  assign conv_go_o = (state_q == S_GO);
  assign pwr_on_o  = burst_i ? (en_i | busy_o) : en_i;

  always_comb begin
    unique case (state_q)
      S_IDLE:                 track_o = idle_tracks & pwr_on_o;
      S_POST_SAR, S_POST_SYS: track_o = 1'b1;
      default:                track_o = 1'b0;
    endcase
  end

  AST_GO_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_go_o |=> !conv_go_o); // R9

  AST_DONE_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CONV && sar_done_i) |=> !busy_o); // R9

  AST_START_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_CONV && start_i && !sar_done_i) |=> (state_q == S_CONV)); // R10

  AST_BURST_POWERED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (burst_i && state_q == S_POST_SAR) |-> pwr_on_o); // R8

  AST_GO_AFTER_TRACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(conv_go_o) && post_needed |-> $past(track_o)); // R3

  AST_SAR_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == S_POST_SAR && !sar_tick_i) |=> (state_q == S_POST_SAR)); // R5

endmodule

// File: rtl/adc_track_seq.sv
module adc_track_seq
  import adc_track_pkg::*;
#(
  parameter int unsigned STEP_CYCLES = 40
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_we_i,
  input  logic [7:0] cfg_wdata_i,
  output logic [7:0] cfg_o,
  input  logic       en_i,
  input  logic       burst_i,
  input  logic       sar_tick_i,
  input  logic       start_i,
  input  logic       sar_done_i,
  output logic       pwr_on_o,
  output logic       track_o,
  output logic       conv_go_o,
  output logic       busy_o
);

  localparam int unsigned STARTUP_MAX = 16 * STEP_CYCLES;
  localparam int unsigned CW          = $clog2(STARTUP_MAX + 1);

  cfg_t          cfg;
  logic          tmr_load;
  logic [CW-1:0] tmr_val;
  logic          tmr_dec;
  logic          tmr_zero;

  adc_track_cfg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  adc_track_timer #(.CW(CW)) u_tmr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .dec_i      (tmr_dec),
    .zero_o     (tmr_zero)
  );

  adc_track_fsm #(.STEP_CYCLES(STEP_CYCLES), .CW(CW)) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_i      (cfg),
    .en_i       (en_i),
    .burst_i    (burst_i),
    .sar_tick_i (sar_tick_i),
    .start_i    (start_i),
    .sar_done_i (sar_done_i),
    .zero_i     (tmr_zero),
    .load_o     (tmr_load),
    .load_val_o (tmr_val),
    .dec_o      (tmr_dec),
    .pwr_on_o   (pwr_on_o),
    .track_o    (track_o),
    .conv_go_o  (conv_go_o),
    .busy_o     (busy_o)
  );

  assign cfg_o = cfg;

endmodule

// File: tb/adc_track_seq_test.sv
`timescale 1ns/1ps
module adc_track_seq_test;

  localparam int STEP = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic [7:0] cfg_rd;
  logic       en = 1'b0;
  logic       burst = 1'b0;
  logic       sar_tick = 1'b1;
  logic       start = 1'b0;
  logic       sar_done = 1'b0;
  logic       pwr_on, track, conv_go, busy;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  adc_track_seq #(.STEP_CYCLES(STEP)) uut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .cfg_we_i    (cfg_we),
    .cfg_wdata_i (cfg_wdata),
    .cfg_o       (cfg_rd),
    .en_i        (en),
    .burst_i     (burst),
    .sar_tick_i  (sar_tick),
    .start_i     (start),
    .sar_done_i  (sar_done),
    .pwr_on_o    (pwr_on),
    .track_o     (track),
    .conv_go_o   (conv_go),
    .busy_o      (busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // pulse start, return edges until conv_go seen; also first-cycle track value
  task automatic launch(output int lat, output logic trk1, output logic pwr1);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    trk1 = track;
    pwr1 = pwr_on;
    lat = 1;
    while (!conv_go && lat < 2000) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic finish_conv(input string req);
    @(negedge clk);
    check(track == 1'b0, req, track, 0);
    sar_done = 1'b1;
    @(negedge clk);
    sar_done = 1'b0;
    check(busy == 1'b0, "R9 busy clears", busy, 0);
  endtask

  task automatic t_reset;
    check(cfg_rd == 8'hFF, "R1 reset cfg", cfg_rd, 255);
    check(busy == 1'b0 && conv_go == 1'b0, "R9 reset idle", busy, 0);
    check(pwr_on == 1'b0, "R6 reset power", pwr_on, 0);
  endtask

  task automatic t_cfg;
    write_cfg(8'h5A);
    check(cfg_rd == 8'h5A, "R1 cfg write", cfg_rd, 8'h5A);
  endtask

  task automatic t_pre;
    int lat; logic t1, p1;
    en = 1'b1; burst = 1'b0;
    write_cfg(8'h08);
    check(track == 1'b1, "R2 idle track", track, 1);
    launch(lat, t1, p1);
    check(lat == 1, "R2 go latency", lat, 1);
    check(track == 1'b0, "R2 hold at go", track, 0);
    @(negedge clk);
    check(conv_go == 1'b0, "R9 go width", conv_go, 0);
    finish_conv("R2 hold in conv");
  endtask

  task automatic t_post;
    for (int k = 0; k < 4; k++) begin
      int lat; logic t1, p1;
      write_cfg(8'h04 | 8'(k));
      check(track == 1'b0, "R3 idle hold", track, 0);
      launch(lat, t1, p1);
      check(t1 == 1'b1, "R3 tracking", t1, 1);
      check(lat == 3 + (2 << k), "R3 post latency", lat, 3 + (2 << k));
      finish_conv("R3 hold in conv");
    end
  endtask

  task automatic t_dual;
    int lat; logic t1, p1;
    write_cfg(8'h0D);
    check(track == 1'b1, "R4 idle track", track, 1);
    launch(lat, t1, p1);
    check(t1 == 1'b1, "R4 post track", t1, 1);
    check(lat == 7, "R4 latency", lat, 7);
    finish_conv("R4 hold in conv");
  endtask

  task automatic t_reserved;
    int lat; logic t1, p1;
    write_cfg(8'h00);
    check(track == 1'b0, "R11 idle hold", track, 0);
    launch(lat, t1, p1);
    check(lat == 5, "R11 latency", lat, 5);
    finish_conv("R11 hold in conv");
  endtask

  task automatic t_tick;
    int lat;
    write_cfg(8'h04);
    @(negedge clk);
    sar_tick = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      check(conv_go == 1'b0 && track == 1'b1, "R5 stalled", conv_go, 0);
      @(negedge clk);
    end
    sar_tick = 1'b1;
    lat = 0;
    while (!conv_go && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 4, "R5 resume latency", lat, 4);
    finish_conv("R5 hold in conv");
  endtask

  task automatic t_power;
    int lat; logic t1, p1;
    burst = 1'b0; en = 1'b0;
    @(negedge clk);
    check(pwr_on == 1'b0, "R6 off", pwr_on, 0);
    en = 1'b1;
    @(negedge clk);
    check(pwr_on == 1'b1, "R6 on", pwr_on, 1);
    burst = 1'b1;
    write_cfg(8'h08);
    check(pwr_on == 1'b1, "R7 idle on", pwr_on, 1);
    launch(lat, t1, p1);
    check(p1 == 1'b1 && pwr_on == 1'b1, "R7 conv on", pwr_on, 1);
    finish_conv("R7 hold in conv");
    check(pwr_on == 1'b1, "R7 after on", pwr_on, 1);
    en = 1'b0;
    write_cfg(8'h28);
    check(pwr_on == 1'b0, "R8 idle low", pwr_on, 0);
    launch(lat, t1, p1);
    check(p1 == 1'b1, "R8 wake", p1, 1);
    check(t1 == 1'b0, "R8 no track in startup", t1, 0);
    check(lat == 3 * STEP + 1, "R8 pre latency", lat, 3 * STEP + 1);
    finish_conv("R8 hold in conv");
    check(pwr_on == 1'b0, "R8 sleep again", pwr_on, 0);
    write_cfg(8'h04);
    launch(lat, t1, p1);
    check(lat == STEP + 5, "R8 post latency", lat, STEP + 5);
    finish_conv("R8 hold in conv");
    burst = 1'b0; en = 1'b1;
  endtask

  task automatic t_busy;
    int lat; logic t1, p1;
    write_cfg(8'h08);
    launch(lat, t1, p1);
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(conv_go == 1'b0 && busy == 1'b1, "R10 start in conv", conv_go, 0);
      @(negedge clk);
    end
    start = 1'b1; sar_done = 1'b1;
    @(negedge clk);
    start = 1'b0; sar_done = 1'b0;
    for (int i = 0; i < 4; i++) begin
      check(busy == 1'b0 && conv_go == 1'b0, "R10 start with done", busy, 0);
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_cfg();
    t_pre();
    t_post();
    t_dual();
    t_reserved();
    t_tick();
    t_power();
    t_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule